// File: doc/BRIEF.md
# Program Counter and Stack Sequencer

This block controls program flow for a small 8-bit core whose instructions are 13 bits wide. It owns the word-addressed program counter, the stack pointer into byte-wide data memory, and the global interrupt enable. Each cycle it looks at the instruction word fetched from the current program counter. It then either advances by one, or moves into a short multi-cycle sequence for jumps, calls, returns, computed jumps and accumulator/flag saves. While a sequence runs, the fetched word is ignored.

Stack traffic uses a single synchronous byte port. A read issued in one cycle returns its data in the next. The rest of the core handles the cases this block does not decode:

- The accumulator and flags are passed in and loaded back through write strobes.
- The condition of any skip-type instruction arrives as a request.
- The `exec_o` strobe tells the rest of the core whether the current word may have side effects.

Top module: `flow_sequencer`

## Requirements
- R1: While reset is held and right after it, the program counter is 0, the stack pointer holds SP_RESET, the interrupt enable is 0, `exec_o` is 1 and the memory port neither reads nor writes.
- R2: Any word that is not a flow-control opcode advances the program counter by one per cycle, with `exec_o` high.
- R3: A word with bits [12:10] = 110 loads bits [9:0] into the program counter. The following cycle is a bubble with `exec_o` low, so the target runs two cycles after the jump.
- R4: A word with bits [12:10] = 111 is a call that takes two cycles. The first cycle writes the low byte of (PC+1) at the stack pointer and loads bits [9:0] into the PC. The second cycle writes the high byte at stack pointer + 1 and raises the stack pointer by 2.
- R5: Return (0x03A) takes three cycles. It reads the high byte at SP-1 and then the low byte at SP-2, loads them into the PC and lowers the stack pointer by 2.
- R6: Return-with-literal (bits [12:8] = 00001) writes bits [7:0] to the accumulator in its first cycle, then returns as in R5.
- R7: 0x038 sets the interrupt enable and 0x039 clears it. Return-from-interrupt (0x03B) returns as in R5 and also sets the interrupt enable.
- R8: 0x032 writes the accumulator at SP in its first cycle. The next cycle writes the flags at SP+1 as {4'b0, flags} and raises SP by 2.
- R9: 0x033 takes three cycles. It restores the four flags from the byte at SP-1, restores the accumulator from the byte at SP-2, and lowers SP by 2.
- R10: 0x017 sets the PC to PC+1+ACC modulo 2^PCW, followed by one bubble, so an accumulator of 0 falls through to the next word.
- R11: When `skip_req_i` is high during an executing cycle of a plain word, the next word takes one cycle with `exec_o` low. That word causes no PC jump, stack move or memory write, and only that one word is squashed.
- R12: The stack pointer only ever changes by exactly ±2, and the memory port never reads and writes in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| instr_i | input | 13 | Instruction word at `pc_o` |
| skip_req_i | input | 1 | Current word's skip condition is true |
| acc_i | input | 8 | Current accumulator value |
| flags_i | input | 4 | Current flag bits |
| mem_rdata_i | input | 8 | Read data, valid the cycle after the read |
| pc_o | output | PCW | Program counter |
| sp_o | output | AW | Stack pointer |
| exec_o | output | 1 | Current word executes |
| gie_o | output | 1 | Global interrupt enable |
| mem_addr_o | output | AW | Data memory address |
| mem_wdata_o | output | 8 | Data memory write data |
| mem_we_o | output | 1 | Data memory write |
| mem_re_o | output | 1 | Data memory read |
| acc_we_o | output | 1 | Accumulator load strobe |
| acc_wdata_o | output | 8 | Accumulator load value |
| flags_we_o | output | 1 | Flags load strobe |
| flags_wdata_o | output | 4 | Flags load value |

## Verification
The bench places a call at an address whose return value crosses a byte boundary. A design that swapped the pushed byte order, or dropped the upper return bits, would come back to the wrong word. Computed jumps are driven with a zero accumulator and with a sum that overflows the counter: an adder lacking the +1 would hang on itself, and one without wrap would leave the program space. A squashed jump and a squashed push are checked for a missing side effect. The word after them is checked to run, which catches a design that squashes two words. A push followed by a pop after the accumulator and flags have been overwritten exposes swapped slots or a wrong read address.

// File: rtl/flow_seq_pkg.sv
package flow_seq_pkg;

    typedef enum logic [2:0] {
        ST_RUN,
        ST_BUBBLE,
        ST_PUSH_HI,
        ST_POP_F,
        ST_POP_A,
        ST_RET_HI,
        ST_RET_LO
    } seq_state_e;

    typedef enum logic [3:0] {
        OP_OTHER,
        OP_JUMP,
        OP_CALL,
        OP_RET,
        OP_RETI,
        OP_RETK,
        OP_PUSHAF,
        OP_POPAF,
        OP_PCADD,
        OP_GIE_ON,
        OP_GIE_OFF
    } flow_op_e;

endpackage

// File: rtl/flow_seq_decode.sv
module flow_seq_decode
    import flow_seq_pkg::*;
(
    input  logic [12:0] instr_i,
    output flow_op_e    op_o
);

    always_comb begin
        op_o = OP_OTHER;
        if (instr_i[12:11] == 2'b11) begin
            op_o = instr_i[10] ? OP_CALL : OP_JUMP;
        end else if (instr_i[12:8] == 5'b00001) begin
            op_o = OP_RETK;
        end else begin
            case (instr_i)
                13'h0017: op_o = OP_PCADD;
                13'h0032: op_o = OP_PUSHAF;
                13'h0033: op_o = OP_POPAF;
                13'h0038: op_o = OP_GIE_ON;
                13'h0039: op_o = OP_GIE_OFF;
                13'h003A: op_o = OP_RET;
                13'h003B: op_o = OP_RETI;
                default:  op_o = OP_OTHER;
            endcase
        end
    end

endmodule

// File: rtl/flow_seq_stackaddr.sv
module flow_seq_stackaddr #(
    parameter int AW = 8
) (
    input  logic [AW-1:0] sp_i,
    output logic [AW-1:0] sp_p1_o,
    output logic [AW-1:0] sp_p2_o,
    output logic [AW-1:0] sp_m1_o,
    output logic [AW-1:0] sp_m2_o
);

    localparam logic [AW-1:0] ONE = AW'(1);
    localparam logic [AW-1:0] TWO = AW'(2);

    always_comb begin
        sp_p1_o = sp_i + ONE;
        sp_p2_o = sp_i + TWO;
        sp_m1_o = sp_i - ONE;
        sp_m2_o = sp_i - TWO;
    end

endmodule

// File: rtl/flow_sequencer.sv
module flow_sequencer
    import flow_seq_pkg::*;
#(
    parameter int          PCW      = 10,
    parameter int          AW       = 8,
    parameter logic [7:0]  SP_RESET = 8'h10
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic [12:0]    instr_i,
    input  logic           skip_req_i,
    input  logic [7:0]     acc_i,
    input  logic [3:0]     flags_i,
    input  logic [7:0]     mem_rdata_i,
    output logic [PCW-1:0] pc_o,
    output logic [AW-1:0]  sp_o,
    output logic           exec_o,
    output logic           gie_o,
    output logic [AW-1:0]  mem_addr_o,
    output logic [7:0]     mem_wdata_o,
    output logic           mem_we_o,
    output logic           mem_re_o,
    output logic           acc_we_o,
    output logic [7:0]     acc_wdata_o,
    output logic           flags_we_o,
    output logic [3:0]     flags_wdata_o
);

    localparam logic [PCW-1:0] PC_ONE = PCW'(1);
    localparam logic [AW-1:0]  SP_INIT = AW'(SP_RESET);

    typedef struct packed {
        seq_state_e     st;
        logic [PCW-1:0] pc;
        logic [AW-1:0]  sp;
        logic           gie;
        logic           squash;
        logic           reti;
        logic [7:0]     hi;
    } seq_regs_t;

    seq_regs_t r_d, r_q;
    flow_op_e  op;
    logic [PCW-1:0] pc_plus1;
    logic [AW-1:0]  sp_p1, sp_p2, sp_m1, sp_m2;

    flow_seq_decode i_dec (
        .instr_i (instr_i),
        .op_o    (op)
    );

    flow_seq_stackaddr #(.AW(AW)) i_spa (
        .sp_i    (r_q.sp),
        .sp_p1_o (sp_p1),
        .sp_p2_o (sp_p2),
        .sp_m1_o (sp_m1),
        .sp_m2_o (sp_m2)
    );

    assign pc_plus1 = r_q.pc + PC_ONE;

    always_comb begin
        r_d           = r_q;
        mem_addr_o    = r_q.sp;
        mem_wdata_o   = 8'h00;
        mem_we_o      = 1'b0;
        mem_re_o      = 1'b0;
        acc_we_o      = 1'b0;
        acc_wdata_o   = 8'h00;
        flags_we_o    = 1'b0;
        flags_wdata_o = 4'h0;
        case (r_q.st)
            ST_RUN: begin
                if (r_q.squash) begin
                    r_d.squash = 1'b0;
                    r_d.pc     = pc_plus1;
                end else begin
                    case (op)
                        OP_JUMP: begin
                            r_d.pc = PCW'(instr_i[9:0]);
                            r_d.st = ST_BUBBLE;
                        end
                        OP_CALL: begin
                            mem_we_o    = 1'b1;
                            mem_wdata_o = pc_plus1[7:0];
                            r_d.hi      = 8'(pc_plus1 >> 8);
                            r_d.pc      = PCW'(instr_i[9:0]);
                            r_d.st      = ST_PUSH_HI;
                        end
                        OP_RET, OP_RETI, OP_RETK: begin
                            mem_re_o   = 1'b1;
                            mem_addr_o = sp_m1;
                            r_d.reti   = (op == OP_RETI);
                            r_d.st     = ST_RET_HI;
                            if (op == OP_RETK) begin
                                acc_we_o    = 1'b1;
                                acc_wdata_o = instr_i[7:0];
                            end
                        end
                        OP_PUSHAF: begin
                            mem_we_o    = 1'b1;
                            mem_wdata_o = acc_i;
                            r_d.hi      = {4'h0, flags_i};
                            r_d.pc      = pc_plus1;
                            r_d.st      = ST_PUSH_HI;
                        end
                        OP_POPAF: begin
                            mem_re_o   = 1'b1;
                            mem_addr_o = sp_m1;
                            r_d.pc     = pc_plus1;
                            r_d.st     = ST_POP_F;
                        end
                        OP_PCADD: begin
                            r_d.pc = pc_plus1 + PCW'(acc_i);
                            r_d.st = ST_BUBBLE;
                        end
                        OP_GIE_ON: begin
                            r_d.gie = 1'b1;
                            r_d.pc  = pc_plus1;
                        end
                        OP_GIE_OFF: begin
                            r_d.gie = 1'b0;
                            r_d.pc  = pc_plus1;
                        end
                        default: begin
                            r_d.pc     = pc_plus1;
                            r_d.squash = skip_req_i;
                        end
                    endcase
                end
            end
            ST_BUBBLE: r_d.st = ST_RUN;
            ST_PUSH_HI: begin
                mem_we_o    = 1'b1;
                mem_addr_o  = sp_p1;
                mem_wdata_o = r_q.hi;
                r_d.sp      = sp_p2;
                r_d.st      = ST_RUN;
            end
            ST_POP_F: begin
                flags_we_o    = 1'b1;
                flags_wdata_o = mem_rdata_i[3:0];
                mem_re_o      = 1'b1;
                mem_addr_o    = sp_m2;
                r_d.st        = ST_POP_A;
            end
            ST_POP_A: begin
                acc_we_o    = 1'b1;
                acc_wdata_o = mem_rdata_i;
                r_d.sp      = sp_m2;
                r_d.st      = ST_RUN;
            end
            ST_RET_HI: begin
                r_d.hi     = mem_rdata_i;
                mem_re_o   = 1'b1;
                mem_addr_o = sp_m2;
                r_d.st     = ST_RET_LO;
            end
            ST_RET_LO: begin
                r_d.pc = PCW'({r_q.hi, mem_rdata_i});
                r_d.sp = sp_m2;
                if (r_q.reti) r_d.gie = 1'b1;
                r_d.st = ST_RUN;
            end
            default: r_d.st = ST_RUN;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_q.st     <= ST_RUN;
            r_q.pc     <= '0;
            r_q.sp     <= SP_INIT;
            r_q.gie    <= 1'b0;
            r_q.squash <= 1'b0;
            r_q.reti   <= 1'b0;
            r_q.hi     <= 8'h00;
        end else begin
            r_q <= r_d;
        end
    end

    assign pc_o   = r_q.pc;
    assign sp_o   = r_q.sp;
    assign gie_o  = r_q.gie;
    assign exec_o = (r_q.st == ST_RUN) && !r_q.squash;

    AST_PORT_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(mem_we_o && mem_re_o)); // R12
    AST_SP_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.sp != $past(r_q.sp)) |->
        (r_q.sp == $past(r_q.sp) + AW'(2) || r_q.sp == $past(r_q.sp) - AW'(2))); // R12
    AST_JUMP_TARGET: assert property (@(posedge clk) disable iff (!rst_n)
        (exec_o && op == OP_JUMP) |=> (r_q.pc == PCW'($past(instr_i[9:0])) && !exec_o)); // R3
    AST_CALL_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        (exec_o && op == OP_CALL) |-> (mem_we_o && mem_wdata_o == pc_plus1[7:0])); // R4
    AST_SQUASH_ONE: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.st == ST_RUN && r_q.squash) |=> (!r_q.squash && r_q.pc == $past(r_q.pc) + PC_ONE)); // R11
    AST_RETI_GIE: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.st == ST_RET_LO && r_q.reti) |=> r_q.gie); // R7

endmodule

// File: tb/test_flow_sequencer.sv
module test_flow_sequencer;

    localparam int         PCW = 10;
    localparam int         AW  = 8;
    localparam logic [7:0] SP0 = 8'h10;

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic [12:0]    instr;
    logic           skip_req = 1'b0;
    logic [7:0]     acc_m = 8'h00;
    logic [3:0]     flags_m = 4'h0;
    logic [7:0]     rdata = 8'h00;
    logic [PCW-1:0] pc;
    logic [AW-1:0]  sp, maddr;
    logic           exec, gie, we, re, acc_we, flags_we;
    logic [7:0]     wdata, acc_wd;
    logic [3:0]     flags_wd;

    logic [12:0] rom [0:1023];
    logic [7:0]  dmem [0:255];
    int total = 0;
    int bad = 0;

    always #2 clk = ~clk;

    assign instr = rom[pc];

    always @(posedge clk) begin
        if (we) dmem[maddr] <= wdata;
        if (re) rdata <= dmem[maddr];
        if (acc_we) acc_m <= acc_wd;
        if (flags_we) flags_m <= flags_wd;
    end

    flow_sequencer #(.PCW(PCW), .AW(AW), .SP_RESET(SP0)) i_flow_sequencer (
        .clk(clk), .rst_n(rst_n), .instr_i(instr), .skip_req_i(skip_req),
        .acc_i(acc_m), .flags_i(flags_m), .mem_rdata_i(rdata),
        .pc_o(pc), .sp_o(sp), .exec_o(exec), .gie_o(gie),
        .mem_addr_o(maddr), .mem_wdata_o(wdata), .mem_we_o(we), .mem_re_o(re),
        .acc_we_o(acc_we), .acc_wdata_o(acc_wd),
        .flags_we_o(flags_we), .flags_wdata_o(flags_wd)
    );

    function automatic logic [12:0] op_jump(input logic [9:0] k); return 13'h1800 | 13'(k); endfunction
    function automatic logic [12:0] op_call(input logic [9:0] k); return 13'h1C00 | 13'(k); endfunction
    function automatic logic [12:0] op_retk(input logic [7:0] k); return 13'h0100 | 13'(k); endfunction

    task automatic check(input string req, input string what, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic step(input int n);
        for (int i = 0; i < n; i++) begin
            @(posedge clk);
            #1;
        end
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        skip_req = 1'b0;
        for (int i = 0; i < 1024; i++) rom[i] = 13'h0000;
        for (int i = 0; i < 256; i++) dmem[i] = 8'h00;
        step(2);
        rst_n = 1'b1;
        #1;
    endtask

    task automatic t_reset();
        do_reset();
        check("R1", "pc", int'(pc), 0);
        check("R1", "sp", int'(sp), int'(SP0));
        check("R1", "gie", int'(gie), 0);
        check("R1", "exec", int'(exec), 1);
        check("R1", "port idle", int'(we | re), 0);
    endtask

    task automatic t_seq();
        do_reset();
        step(3);
        check("R2", "pc after 3 words", int'(pc), 3);
        check("R2", "exec", int'(exec), 1);
    endtask

    task automatic t_call_ret();
        do_reset();
        rom[0]       = op_jump(10'h1FE);
        rom[10'h1FE] = op_call(10'h2A3);
        rom[10'h2A3] = 13'h003A;
        step(1);
        check("R3", "jump pc", int'(pc), 'h1FE);
        check("R3", "bubble exec", int'(exec), 0);
        step(1);
        check("R3", "target exec", int'(exec), 1);
        check("R4", "low byte write", int'({we, wdata}), 'h1FF);
        step(1);
        check("R4", "call pc", int'(pc), 'h2A3);
        check("R4", "mem low", int'(dmem[SP0]), 'hFF);
        step(1);
        check("R4", "mem high", int'(dmem[SP0 + 8'd1]), 'h01);
        check("R12", "sp after call", int'(sp), int'(SP0) + 2);
        step(1);
        check("R5", "return wait exec", int'(exec), 0);
        step(2);
        check("R5", "return pc", int'(pc), 'h1FF);
        check("R5", "return sp", int'(sp), int'(SP0));
    endtask

    task automatic t_retk();
        do_reset();
        acc_m = 8'h00;
        rom[0]     = op_call(10'h020);
        rom[10'h20] = op_retk(8'h5A);
        step(3);
        check("R6", "acc literal", int'(acc_m), 'h5A);
        step(2);
        check("R6", "return pc", int'(pc), 1);
        check("R6", "return sp", int'(sp), int'(SP0));
    endtask

    task automatic t_gie();
        do_reset();
        rom[0]      = 13'h0038;
        rom[1]      = 13'h0039;
        rom[2]      = op_call(10'h040);
        rom[10'h40] = 13'h003B;
        step(1);
        check("R7", "enable", int'(gie), 1);
        step(1);
        check("R7", "disable", int'(gie), 0);
        step(5);
        check("R7", "reti pc", int'(pc), 3);
        check("R7", "reti gie", int'(gie), 1);
    endtask

    task automatic t_push_pop();
        do_reset();
        acc_m = 8'hC3;
        flags_m = 4'h5;
        rom[0] = 13'h0032;
        rom[1] = 13'h0033;
        step(1);
        check("R8", "acc slot", int'(dmem[SP0]), 'hC3);
        step(1);
        check("R8", "flag slot", int'(dmem[SP0 + 8'd1]), 'h05);
        check("R8", "sp", int'(sp), int'(SP0) + 2);
        acc_m = 8'h00;
        flags_m = 4'h0;
        step(2);
        check("R9", "flags restored", int'(flags_m), 5);
        step(1);
        check("R9", "acc restored", int'(acc_m), 'hC3);
        check("R9", "sp", int'(sp), int'(SP0));
        check("R9", "pc", int'(pc), 2);
    endtask

    task automatic t_pcadd();
        do_reset();
        acc_m = 8'h05;
        rom[0] = 13'h0017;
        step(1);
        check("R10", "pc+1+5", int'(pc), 6);
        check("R10", "bubble", int'(exec), 0);
        do_reset();
        acc_m = 8'h00;
        rom[0] = 13'h0017;
        step(1);
        check("R10", "zero falls through", int'(pc), 1);
        do_reset();
        acc_m = 8'hFF;
        rom[0]       = op_jump(10'h3FE);
        rom[10'h3FE] = 13'h0017;
        step(3);
        check("R10", "wrap", int'(pc), 'h0FE);
    endtask

    task automatic t_skip();
        do_reset();
        rom[1] = 13'h0032;
        skip_req = 1'b1;
        step(1);
        skip_req = 1'b0;
        check("R11", "squashed exec", int'(exec), 0);
        check("R11", "no write", int'(we), 0);
        step(1);
        check("R11", "pc", int'(pc), 2);
        check("R11", "sp", int'(sp), int'(SP0));
        check("R11", "next runs", int'(exec), 1);
        do_reset();
        rom[1] = op_jump(10'h100);
        skip_req = 1'b1;
        step(1);
        skip_req = 1'b0;
        step(1);
        check("R11", "skipped jump", int'(pc), 2);
    endtask

    initial begin
        t_reset();
        t_seq();
        t_call_ret();
        t_retk();
        t_gie();
        t_push_pop();
        t_pcadd();
        t_skip();
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL R2 watchdog: actual=hung expected=done");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule